// File: doc/BRIEF.md
# Decode-Stage Early Branch Unit

This block sits in the decode stage of a five-stage in-order pipeline. It inspects every instruction that leaves decode and finds the program-counter writes that can be settled early. There are two kinds: an unconditional add of an immediate offset to the PC, and an unconditional load of an immediate into the PC. For either kind it forms the target address at once and sends a one-cycle redirect to fetch. The only cost is the single younger instruction that fetch has already picked up.

Every other PC write is left to write-back, which presents its own redirect on a separate input. That covers conditional forms, register-sourced values and loads from memory. The unit passes the late redirect straight through to fetch and raises flushes for every stage ahead of write-back. A parameter selects a pipelined-fetch variant, which adds one register stage and therefore one more bubble to the early path.

Top module: `early_branch_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `fetch_redir_valid_o` is 0 and `flush_o` is all zeros.
- R2: An accepted decode instruction (valid high, stall low) with opcode 4'h2 (add), destination register 4'hF (PC), condition 3'd0 (always) and immediate operand select 1 gives a redirect. The redirect comes LAT cycles after acceptance (LAT = 1, or 2 with pipelined fetch). Its address is `dec_next_pc_i` plus the sign-extended low 18 bits of `dec_imm_i`.
- R3: For the add form only the low 18 bits of the immediate count; bit 17 is the sign. An offset of all ones (-1) targets the branch instruction itself, because `dec_next_pc_i` is the address after the branch.
- R4: An accepted opcode 4'h6 (load immediate) to PC, always-condition, immediate select 1 redirects to the 23-bit immediate sign-extended to 32 bits, LAT cycles after acceptance.
- R5: A nonzero condition field suppresses the early redirect for both opcodes.
- R6: No early redirect comes from another destination register, from immediate select 0 (register operand), or from any other opcode.
- R7: Each early branch gives a redirect for exactly one cycle. No redirect is produced while decode is stalled, and a branch held under stall redirects once after the stall is released.
- R8: A write-back redirect drives `fetch_redir_valid_o` high in the same cycle, with `fetch_redir_addr_o` equal to the write-back address and every bit of `flush_o` set.
- R9: A write-back redirect takes priority over an early one. An early branch decoded in the same cycle, or still in flight in the pipelined variant, is dropped and never redirects.
- R10: With an early redirect, `flush_o` has set only its LAT lowest bits, where bit 0 is fetch and bit 1 is decode: 4'b0001 normally and 4'b0011 with pipelined fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid_i | input | 1 | Decode holds a valid instruction |
| dec_stall_i | input | 1 | Decode is stalled this cycle |
| dec_op_i | input | 4 | Opcode (4'h2 add, 4'h6 load immediate) |
| dec_dst_i | input | 4 | Destination register, 4'hF is PC |
| dec_cond_i | input | 3 | Condition code, 0 means always |
| dec_imm_sel_i | input | 1 | 1 = immediate operand, 0 = register operand |
| dec_imm_i | input | 23 | Immediate field |
| dec_next_pc_i | input | 32 | Address of the instruction after this one |
| wb_redir_valid_i | input | 1 | Write-back stage redirect request |
| wb_redir_addr_i | input | 32 | Write-back redirect target |
| fetch_redir_valid_o | output | 1 | Redirect fetch this cycle |
| fetch_redir_addr_o | output | 32 | Redirect target |
| flush_o | output | 4 | Per-stage flush, bit 0 fetch up to bit 3 memory |

## Verification
The target computation is driven with small positive and negative offsets, the extreme negative 18-bit offset and a -1 busy loop. It is also driven with junk in the immediate's upper bits, which shows whether the sign comes from bit 17 or from a wider field. Load-immediate values with bit 22 clear and set show whether the absolute path uses its own sign extension. Near-miss encodings must not redirect: a condition, a non-PC destination, a register operand and a foreign opcode. Held stalls and simultaneous or overlapping write-back redirects test the single-redirect rule and the priority. Both the one-cycle and the pipelined-fetch variant run side by side, which separates the latency and flush-mask differences.

// File: rtl/ebu_pkg.sv
package ebu_pkg;
   localparam logic [3:0] OP_ADD      = 4'h2;
   localparam logic [3:0] OP_LDI      = 4'h6;
   localparam logic [3:0] REG_PC      = 4'hF;
   localparam logic [2:0] COND_ALWAYS = 3'd0;

   typedef enum logic [1:0] {
      BK_NONE = 2'd0,
      BK_REL  = 2'd1,
      BK_ABS  = 2'd2
   } ebu_kind_e;
endpackage

// File: rtl/ebu_decode.sv
module ebu_decode
   import ebu_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int REL_W  = 18,
   parameter int LDI_W  = 23
) (
   input  logic [3:0]        op_i,
   input  logic [3:0]        dst_i,
   input  logic [2:0]        cond_i,
   input  logic              imm_sel_i,
   input  logic [LDI_W-1:0]  imm_i,
   input  logic [ADDR_W-1:0] next_pc_i,
   output logic              hit_o,
   output logic [ADDR_W-1:0] target_o
);
   ebu_kind_e         kind;
   logic [ADDR_W-1:0] rel_off;
   logic [ADDR_W-1:0] abs_val;

   always_comb begin
      kind = BK_NONE;
      if (dst_i == REG_PC && cond_i == COND_ALWAYS && imm_sel_i) begin
         case (op_i)
            OP_ADD:  kind = BK_REL;
            OP_LDI:  kind = BK_ABS;
            default: kind = BK_NONE;
         endcase
      end
   end

   assign rel_off  = {{(ADDR_W-REL_W){imm_i[REL_W-1]}}, imm_i[REL_W-1:0]};
   assign abs_val  = {{(ADDR_W-LDI_W){imm_i[LDI_W-1]}}, imm_i};
   assign hit_o    = (kind != BK_NONE);
   assign target_o = (kind == BK_REL) ? (next_pc_i + rel_off) : abs_val;
endmodule

// File: rtl/ebu_redir_pipe.sv
module ebu_redir_pipe #(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kill_i,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              vld_o,
   output logic [ADDR_W-1:0] addr_o
);
   logic              vld_q  [DEPTH];
   logic [ADDR_W-1:0] addr_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n || kill_i) begin
               vld_q[i]  <= 1'b0;
               addr_q[i] <= '0;
            end else begin
               vld_q[i]  <= load_i;
               addr_q[i] <= addr_i;
            end
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (!rst_n || kill_i) begin
               vld_q[i]  <= 1'b0;
               addr_q[i] <= '0;
            end else begin
               vld_q[i]  <= vld_q[i-1];
               addr_q[i] <= addr_q[i-1];
            end
         end
      end
   end

   assign vld_o  = vld_q[DEPTH-1];
   assign addr_o = addr_q[DEPTH-1];
endmodule

// File: rtl/ebu_redir_arb.sv
module ebu_redir_arb #(
   parameter int ADDR_W = 32,
   parameter int NFLUSH = 4,
   parameter int LAT    = 1
) (
   input  logic              early_vld_i,
   input  logic [ADDR_W-1:0] early_addr_i,
   input  logic              wb_vld_i,
   input  logic [ADDR_W-1:0] wb_addr_i,
   output logic              vld_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [NFLUSH-1:0] flush_o
);
   localparam logic [NFLUSH-1:0] EARLY_MASK = NFLUSH'((1 << LAT) - 1);

   always_comb begin
      vld_o   = 1'b0;
      addr_o  = early_addr_i;
      flush_o = '0;
      if (wb_vld_i) begin
         vld_o   = 1'b1;
         addr_o  = wb_addr_i;
         flush_o = '1;
      end else if (early_vld_i) begin
         vld_o   = 1'b1;
         flush_o = EARLY_MASK;
      end
   end
endmodule

// File: rtl/early_branch_unit.sv
module early_branch_unit #(
   parameter int ADDR_W     = 32,
   parameter int REL_W      = 18,
   parameter int LDI_W      = 23,
   parameter int NUM_STAGES = 5,
   parameter bit FETCH_PIPE = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    dec_valid_i,
   input  logic                    dec_stall_i,
   input  logic [3:0]              dec_op_i,
   input  logic [3:0]              dec_dst_i,
   input  logic [2:0]              dec_cond_i,
   input  logic                    dec_imm_sel_i,
   input  logic [LDI_W-1:0]        dec_imm_i,
   input  logic [ADDR_W-1:0]       dec_next_pc_i,
   input  logic                    wb_redir_valid_i,
   input  logic [ADDR_W-1:0]       wb_redir_addr_i,
   output logic                    fetch_redir_valid_o,
   output logic [ADDR_W-1:0]       fetch_redir_addr_o,
   output logic [NUM_STAGES-2:0]   flush_o
);
   localparam int LAT    = FETCH_PIPE ? 2 : 1;
   localparam int NFLUSH = NUM_STAGES - 1;

   if (REL_W >= LDI_W) begin : g_bad_rel
      $error("REL_W must be narrower than LDI_W");
   end
   if (LDI_W >= ADDR_W) begin : g_bad_ldi
      $error("LDI_W must be narrower than ADDR_W");
   end
   if (NUM_STAGES < LAT + 2) begin : g_bad_depth
      $error("NUM_STAGES too small for the selected fetch mode");
   end

   logic              early_hit;
   logic [ADDR_W-1:0] early_tgt;
   logic              early_take;
   logic              pend_vld;
   logic [ADDR_W-1:0] pend_addr;

   ebu_decode #(
      .ADDR_W(ADDR_W), .REL_W(REL_W), .LDI_W(LDI_W)
   ) u_dec (
      .op_i      (dec_op_i),
      .dst_i     (dec_dst_i),
      .cond_i    (dec_cond_i),
      .imm_sel_i (dec_imm_sel_i),
      .imm_i     (dec_imm_i),
      .next_pc_i (dec_next_pc_i),
      .hit_o     (early_hit),
      .target_o  (early_tgt)
   );

   assign early_take = dec_valid_i & ~dec_stall_i & ~wb_redir_valid_i & early_hit;

   ebu_redir_pipe #(
      .ADDR_W(ADDR_W), .DEPTH(LAT)
   ) u_pipe (
      .clk    (clk),
      .rst_n  (rst_n),
      .kill_i (wb_redir_valid_i),
      .load_i (early_take),
      .addr_i (early_tgt),
      .vld_o  (pend_vld),
      .addr_o (pend_addr)
   );

   ebu_redir_arb #(
      .ADDR_W(ADDR_W), .NFLUSH(NFLUSH), .LAT(LAT)
   ) u_arb (
      .early_vld_i  (pend_vld),
      .early_addr_i (pend_addr),
      .wb_vld_i     (wb_redir_valid_i),
      .wb_addr_i    (wb_redir_addr_i),
      .vld_o        (fetch_redir_valid_o),
      .addr_o       (fetch_redir_addr_o),
      .flush_o      (flush_o)
   );
endmodule

// File: rtl/ebu_checker.sv
module ebu_checker #(
   parameter int ADDR_W = 32,
   parameter int NFLUSH = 4,
   parameter int LAT    = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dec_valid,
   input logic              dec_stall,
   input logic [2:0]        dec_cond,
   input logic              hit,
   input logic              wb_valid,
   input logic [ADDR_W-1:0] wb_addr,
   input logic              redir_valid,
   input logic [ADDR_W-1:0] redir_addr,
   input logic [NFLUSH-1:0] flush
);
   // R8
   wb_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (redir_valid && redir_addr == wb_addr && flush == '1));

   // R10
   flush_needs_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush != '0) |-> redir_valid);

   // R10
   early_flush_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (redir_valid && !wb_valid) |-> (flush == NFLUSH'((1 << LAT) - 1)));

   if (LAT == 1) begin : g_lat1
      // R2
      early_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (dec_valid && !dec_stall && hit && !wb_valid) |=> redir_valid);
      // R5
      cond_no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (dec_valid && !dec_stall && dec_cond != 3'd0) |=> (!redir_valid || wb_valid));
      // R7
      stall_no_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
         dec_stall |=> (!redir_valid || wb_valid));
   end else begin : g_lat2
      // R2
      early_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (dec_valid && !dec_stall && hit && !wb_valid) ##1 !wb_valid |=> redir_valid);
   end
endmodule

bind early_branch_unit ebu_checker #(
   .ADDR_W(ADDR_W), .NFLUSH(NUM_STAGES - 1), .LAT(FETCH_PIPE ? 2 : 1)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dec_valid   (dec_valid_i),
   .dec_stall   (dec_stall_i),
   .dec_cond    (dec_cond_i),
   .hit         (early_hit),
   .wb_valid    (wb_redir_valid_i),
   .wb_addr     (wb_redir_addr_i),
   .redir_valid (fetch_redir_valid_o),
   .redir_addr  (fetch_redir_addr_o),
   .flush       (flush_o)
);

// File: tb/early_branch_unit_bench.sv
module early_branch_unit_bench;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [3:0]  op;
      logic [3:0]  dst;
      logic [2:0]  cond;
      logic        sel;
      logic [22:0] imm;
      logic [31:0] pc;
      logic        ev;
      logic [31:0] ea;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{4'h2, 4'hF, 3'd0, 1'b1, 23'h000010, 32'h0000_0100, 1'b1, 32'h0000_0110},
      '{4'h2, 4'hF, 3'd0, 1'b1, 23'h03FFFF, 32'h0000_0201, 1'b1, 32'h0000_0200},
      '{4'h2, 4'hF, 3'd0, 1'b1, 23'h7C0005, 32'h0000_1000, 1'b1, 32'h0000_1005},
      '{4'h2, 4'hF, 3'd0, 1'b1, 23'h020000, 32'h0004_0000, 1'b1, 32'h0002_0000},
      '{4'h6, 4'hF, 3'd0, 1'b1, 23'h123456, 32'h0000_0500, 1'b1, 32'h0012_3456},
      '{4'h6, 4'hF, 3'd0, 1'b1, 23'h400000, 32'h0000_0500, 1'b1, 32'hFFC0_0000},
      '{4'h2, 4'hF, 3'd3, 1'b1, 23'h000010, 32'h0000_0100, 1'b0, 32'h0},
      '{4'h6, 4'hF, 3'd1, 1'b1, 23'h000040, 32'h0000_0100, 1'b0, 32'h0},
      '{4'h2, 4'h3, 3'd0, 1'b1, 23'h000010, 32'h0000_0100, 1'b0, 32'h0},
      '{4'h2, 4'hF, 3'd0, 1'b0, 23'h000010, 32'h0000_0100, 1'b0, 32'h0},
      '{4'h1, 4'hF, 3'd0, 1'b1, 23'h000010, 32'h0000_0100, 1'b0, 32'h0}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        dec_valid, dec_stall, dec_sel, wb_valid;
   logic [3:0]  dec_op, dec_dst;
   logic [2:0]  dec_cond;
   logic [22:0] dec_imm;
   logic [31:0] dec_pc, wb_addr;
   logic        m_vld, p_vld;
   logic [31:0] m_addr, p_addr;
   logic [3:0]  m_flush, p_flush;
   int          n_chk = 0;
   int          n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   early_branch_unit u_early_branch_unit (
      .clk(clk), .rst_n(rst_n), .dec_valid_i(dec_valid), .dec_stall_i(dec_stall),
      .dec_op_i(dec_op), .dec_dst_i(dec_dst), .dec_cond_i(dec_cond),
      .dec_imm_sel_i(dec_sel), .dec_imm_i(dec_imm), .dec_next_pc_i(dec_pc),
      .wb_redir_valid_i(wb_valid), .wb_redir_addr_i(wb_addr),
      .fetch_redir_valid_o(m_vld), .fetch_redir_addr_o(m_addr), .flush_o(m_flush)
   );

   early_branch_unit #(.FETCH_PIPE(1'b1)) u_early_branch_unit_pf (
      .clk(clk), .rst_n(rst_n), .dec_valid_i(dec_valid), .dec_stall_i(dec_stall),
      .dec_op_i(dec_op), .dec_dst_i(dec_dst), .dec_cond_i(dec_cond),
      .dec_imm_sel_i(dec_sel), .dec_imm_i(dec_imm), .dec_next_pc_i(dec_pc),
      .wb_redir_valid_i(wb_valid), .wb_redir_addr_i(wb_addr),
      .fetch_redir_valid_o(p_vld), .fetch_redir_addr_o(p_addr), .flush_o(p_flush)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input int i);
      if (i == 0) return "R2";
      if (i <= 3) return "R3";
      if (i <= 5) return "R4";
      if (i <= 7) return "R5";
      return "R6";
   endfunction

   task automatic idle();
      dec_valid = 1'b0; dec_stall = 1'b0; dec_op = 4'h0; dec_dst = 4'h0;
      dec_cond = 3'd0; dec_sel = 1'b0; dec_imm = '0; dec_pc = '0;
      wb_valid = 1'b0; wb_addr = '0;
   endtask

   task automatic drive(input vec_t v);
      dec_op = v.op; dec_dst = v.dst; dec_cond = v.cond; dec_sel = v.sel;
      dec_imm = v.imm; dec_pc = v.pc; dec_valid = 1'b1;
   endtask

   task automatic run_vec(input vec_t v, input string req);
      @(negedge clk); drive(v);
      @(posedge clk); @(negedge clk); dec_valid = 1'b0; #1;
      chk(req, "main valid", 32'(m_vld), 32'(v.ev));
      if (v.ev) begin
         chk(req, "main addr", m_addr, v.ea);
         chk("R10", "main flush", 32'(m_flush), 32'h1);
      end
      chk(req, "pf valid early", 32'(p_vld), 32'h0);
      @(posedge clk); @(negedge clk); #1;
      chk("R7", "main one cycle", 32'(m_vld), 32'h0);
      chk(req, "pf valid", 32'(p_vld), 32'(v.ev));
      if (v.ev) begin
         chk(req, "pf addr", p_addr, v.ea);
         chk("R10", "pf flush", 32'(p_flush), 32'h3);
      end
      @(posedge clk); @(negedge clk); #1;
      chk("R7", "pf one cycle", 32'(p_vld), 32'h0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      idle();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1
      chk("R1", "valid in reset", 32'(m_vld), 32'h0);
      chk("R1", "flush in reset", 32'(m_flush), 32'h0);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk); #1;
      chk("R1", "valid after reset", 32'(m_vld | p_vld), 32'h0);
      chk("R1", "flush after reset", 32'(m_flush | p_flush), 32'h0);

      for (int i = 0; i < NV; i++) run_vec(VECS[i], req_of(i));

      // R7: held stall gives no redirect, then exactly one on release
      @(negedge clk); drive(VECS[0]); dec_stall = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(posedge clk); @(negedge clk); #1;
         chk("R7", "stalled main", 32'(m_vld), 32'h0);
         chk("R7", "stalled pf", 32'(p_vld), 32'h0);
      end
      dec_stall = 1'b0;
      @(posedge clk); @(negedge clk); dec_valid = 1'b0; #1;
      chk("R7", "release main", 32'(m_vld), 32'h1);
      chk("R7", "release addr", m_addr, 32'h0000_0110);
      @(posedge clk); @(negedge clk); #1;
      chk("R7", "release main once", 32'(m_vld), 32'h0);
      chk("R7", "release pf", 32'(p_vld), 32'h1);
      @(posedge clk); @(negedge clk); #1;
      chk("R7", "release pf once", 32'(p_vld), 32'h0);

      // R8: write-back redirect passes through at once
      @(negedge clk); wb_valid = 1'b1; wb_addr = 32'hDEAD_0000; #1;
      chk("R8", "wb valid", 32'(m_vld & p_vld), 32'h1);
      chk("R8", "wb addr", m_addr, 32'hDEAD_0000);
      chk("R8", "wb flush main", 32'(m_flush), 32'hF);
      chk("R8", "wb flush pf", 32'(p_flush), 32'hF);
      @(posedge clk); @(negedge clk); wb_valid = 1'b0; #1;
      chk("R8", "wb gone", 32'(m_vld | p_vld), 32'h0);

      // R9: same-cycle write-back beats early branch, which is dropped
      @(negedge clk); drive(VECS[0]); wb_valid = 1'b1; wb_addr = 32'h0000_5000; #1;
      chk("R9", "priority addr", m_addr, 32'h0000_5000);
      chk("R9", "priority flush", 32'(m_flush), 32'hF);
      @(posedge clk); @(negedge clk); idle(); #1;
      chk("R9", "dropped main", 32'(m_vld), 32'h0);
      @(posedge clk); @(negedge clk); #1;
      chk("R9", "dropped pf", 32'(p_vld), 32'h0);

      // R9: in-flight early branch of the pipelined variant is killed
      @(negedge clk); drive(VECS[4]);
      @(posedge clk); @(negedge clk); dec_valid = 1'b0;
      wb_valid = 1'b1; wb_addr = 32'h0000_6000; #1;
      chk("R9", "overlap addr", m_addr, 32'h0000_6000);
      chk("R9", "overlap pf addr", p_addr, 32'h0000_6000);
      @(posedge clk); @(negedge clk); wb_valid = 1'b0; #1;
      chk("R9", "killed pf", 32'(p_vld), 32'h0);
      chk("R9", "killed main", 32'(m_vld), 32'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule